// File: doc/BRIEF.md
# Boot Path Selector

This block runs once after every reset release and chooses which of three start-up exits the system takes: the serial programming handler, the user program already held in code memory, or the baud-rate detection routine. It first waits a programmable number of clock cycles so that the external strap has settled. It then samples the boot-request pin through a two-flop synchronizer. At the same instant it captures the watchdog-overflow flag. A low pin asks for the programming handler, but a set watchdog flag cancels that request.

When no request stands, the block checks the code memory. It reads eight consecutive words over a synchronous read port with one cycle of latency and adds them modulo 2^DATA_W. The image is accepted when the total is zero, which is the case when the last word holds the two's complement of the sum of the seven words before it. A zero total selects the user-code exit and any other total selects the baud-detection exit. The chosen exit appears on one of three mutually exclusive select lines, together with a single-cycle done pulse. The select line stays set until the next reset.

Top module: `boot_select`

## Requirements
- R1: While reset is asserted, and in the cycle after it is released, sel_isp, sel_user, sel_autobaud, done and rd_en are all 0.
- R2: The synchronized pin is sampled exactly once, in the cycle after DELAY_CYCLES rising clock edges have occurred since reset release. No memory read is issued before that sample. done rises after edge DELAY_CYCLES+2 on the programming path and after edge DELAY_CYCLES+2+2*NUM_WORDS on the code-check path.
- R3: A pin sampled low (0) with the watchdog flag clear (0) selects sel_isp and issues no memory read.
- R4: A pin sampled low with the watchdog flag set (1) is treated as a high pin, so the code check runs.
- R5: On the code-check path exactly NUM_WORDS reads are issued, at addresses BASE_ADDR+0 up to BASE_ADDR+NUM_WORDS-1 in increasing order. Each read is one rd_en cycle followed by one idle cycle. No read is issued once an exit is selected.
- R6: If the sum of the words read, modulo 2^DATA_W, is zero, sel_user is selected. Wrap-around to exactly 2^DATA_W counts as zero.
- R7: If that sum is nonzero, sel_autobaud is selected.
- R8: At most one select line is ever high. done is high for exactly one cycle, and exactly one select line is high while done is high. The select line then holds its value until reset.
- R9: A reset asserted at any point of the sequence clears the selection and the running sum. After release, the full delay, sample and check sequence restarts.
- R10: Changes on the boot-request pin or the watchdog flag after the sample instant do not change the decision or the held select line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_req_pin | input | 1 | Boot-request strap, low asks for programming handler |
| wdt_overflow | input | 1 | Watchdog-overflow flag, set cancels a strap request |
| rd_en | output | 1 | Code memory read enable |
| rd_addr | output | ADDR_W | Code memory word address |
| rd_data | input | DATA_W | Read data, valid one cycle after rd_en |
| sel_isp | output | 1 | Programming-handler exit selected |
| sel_user | output | 1 | User-code exit selected |
| sel_autobaud | output | 1 | Baud-detection exit selected |
| done | output | 1 | One-cycle pulse when the decision is made |

## Verification
The assertions check these properties on every cycle: the select lines stay exclusive and hold, done lasts a single cycle and carries exactly one exit, reads are spaced, fall inside the word window and never follow an exit, and the sample falls exactly DELAY_CYCLES cycles after reset. They also tie the programming exit to zero reads and the other two exits to a full read count. Only the bench's scenarios can show that the correct exit is chosen for a given strap, flag and memory image. This covers modulo wrap-around of the sum, the watchdog override, late strap changes being ignored, and a reset in the middle of the reads discarding the partial sum.

// File: rtl/boot_select_pkg.sv
package boot_select_pkg;

  typedef enum logic [2:0] {
    ST_WAIT_DELAY,
    ST_SAMPLE,
    ST_READ,
    ST_ACCUM,
    ST_DECIDE,
    ST_DONE
  } boot_state_t;

  typedef struct packed {
    logic isp;
    logic user;
    logic autobaud;
  } boot_exit_t;

  // A strap request stands only if the pin is low and no watchdog overflow is flagged.
  function automatic logic strap_request(input logic pin_level, input logic wdt_flag);
    return (pin_level == 1'b0) && (wdt_flag == 1'b0);
  endfunction

  function automatic boot_exit_t pick_exit(input logic request, input logic image_ok);
    boot_exit_t e;
    e.isp      = request;
    e.user     = !request && image_ok;
    e.autobaud = !request && !image_ok;
    return e;
  endfunction

endpackage

// File: rtl/boot_strap_sync.sv
module boot_strap_sync #(
  parameter int  STAGES    = 2,
  parameter logic RESET_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= {STAGES{RESET_VAL}};
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/boot_delay_timer.sv
module boot_delay_timer #(
  parameter int CYCLES = 300000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CNT_W = (CYCLES < 2) ? 1 : $clog2(CYCLES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt <= '0;
    else if (run && !expired)  cnt <= cnt + 1'b1;
  end

  assign expired = run && (cnt == LAST);
endmodule

// File: rtl/boot_code_summer.sv
module boot_code_summer #(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 8,
  parameter int NUM_WORDS = 8,
  parameter int BASE_ADDR = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic [DATA_W-1:0] word_in,
  output logic [ADDR_W-1:0] word_addr,
  output logic              last_word,
  output logic              sum_zero
);
  localparam int IDX_W = (NUM_WORDS < 2) ? 1 : $clog2(NUM_WORDS);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NUM_WORDS - 1);

  logic [IDX_W-1:0]  idx;
  logic [DATA_W-1:0] acc;

  // Sum that drops the carry out of the top bit.
  function automatic logic [DATA_W-1:0] wrap_add(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b);
    return a + b;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx <= '0;
      acc <= '0;
    end else if (capture) begin
      acc <= wrap_add(acc, word_in);
      idx <= idx + 1'b1;
    end
  end

  assign word_addr = ADDR_W'(BASE_ADDR) + ADDR_W'(idx);
  assign last_word = (idx == IDX_LAST);
  assign sum_zero  = (acc == '0);
endmodule

// File: rtl/boot_select.sv
module boot_select
  import boot_select_pkg::*;
#(
  parameter int DELAY_CYCLES = 300000,
  parameter int DATA_W       = 32,
  parameter int ADDR_W       = 8,
  parameter int NUM_WORDS    = 8,
  parameter int BASE_ADDR    = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_req_pin,
  input  logic              wdt_overflow,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  output logic              sel_isp,
  output logic              sel_user,
  output logic              sel_autobaud,
  output logic              done
);
  boot_state_t state;
  boot_exit_t  exit_q;
  logic        isp_req_q;

  // Named internal events
  logic pin_sync;
  logic delay_done;
  logic sample_fire;
  logic isp_request;
  logic word_capture;
  logic last_word;
  logic sum_zero;
  logic decide_fire;

  boot_strap_sync #(.STAGES(2), .RESET_VAL(1'b1)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (boot_req_pin),
    .q     (pin_sync)
  );

  boot_delay_timer #(.CYCLES(DELAY_CYCLES)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (state == ST_WAIT_DELAY),
    .expired (delay_done)
  );

  boot_code_summer #(
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .NUM_WORDS (NUM_WORDS),
    .BASE_ADDR (BASE_ADDR)
  ) u_summer (
    .clk       (clk),
    .rst_n     (rst_n),
    .capture   (word_capture),
    .word_in   (rd_data),
    .word_addr (rd_addr),
    .last_word (last_word),
    .sum_zero  (sum_zero)
  );

  assign sample_fire  = (state == ST_SAMPLE);
  assign isp_request  = strap_request(pin_sync, wdt_overflow);
  assign word_capture = (state == ST_ACCUM);
  assign decide_fire  = (state == ST_DECIDE);
  assign rd_en        = (state == ST_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_WAIT_DELAY;
      isp_req_q <= 1'b0;
      exit_q    <= '0;
      done      <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_WAIT_DELAY: if (delay_done) state <= ST_SAMPLE;
        ST_SAMPLE: begin
          isp_req_q <= isp_request;
          state     <= isp_request ? ST_DECIDE : ST_READ;
        end
        ST_READ:  state <= ST_ACCUM;
        ST_ACCUM: state <= last_word ? ST_DECIDE : ST_READ;
        ST_DECIDE: begin
          exit_q <= pick_exit(isp_req_q, sum_zero);
          done   <= 1'b1;
          state  <= ST_DONE;
        end
        ST_DONE:  state <= ST_DONE;
        default:  state <= ST_WAIT_DELAY;
      endcase
    end
  end

  assign sel_isp      = exit_q.isp;
  assign sel_user     = exit_q.user;
  assign sel_autobaud = exit_q.autobaud;
endmodule

// File: rtl/boot_select_chk.sv
module boot_select_chk #(
  parameter int DELAY_CYCLES = 300000,
  parameter int NUM_WORDS    = 8,
  parameter int ADDR_W       = 8,
  parameter int BASE_ADDR    = 0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              sel_isp,
  input logic              sel_user,
  input logic              sel_autobaud,
  input logic              done,
  input logic              sample_fire
);
  logic [31:0] cyc;
  logic [31:0] rd_cnt;
  logic [2:0]  sels;

  assign sels = {sel_isp, sel_user, sel_autobaud};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc    <= '0;
      rd_cnt <= '0;
    end else begin
      if (cyc != 32'hFFFF_FFFF) cyc <= cyc + 32'd1;
      if (rd_en) rd_cnt <= rd_cnt + 32'd1;
    end
  end

  AST_SEL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(sels)); // R8
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_HAS_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones(sels) == 1)); // R8
  AST_EXIT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (|sels) |=> $stable(sels)); // R8
  AST_SAMPLE_TIME: assert property (@(posedge clk) disable iff (!rst_n)
    sample_fire |-> (cyc == 32'(DELAY_CYCLES))); // R2
  AST_NO_EARLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (cyc > 32'(DELAY_CYCLES))); // R2
  AST_READ_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en); // R5
  AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ((32'(rd_addr) >= 32'(BASE_ADDR)) &&
               (32'(rd_addr) < 32'(BASE_ADDR + NUM_WORDS)))); // R5
  AST_NO_READ_AFTER_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (|sels) |-> !rd_en); // R5
  AST_ISP_NO_READS: assert property (@(posedge clk) disable iff (!rst_n)
    sel_isp |-> (rd_cnt == 32'd0)); // R3
  AST_CHECK_FULL_READS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_user || sel_autobaud) |-> (rd_cnt == 32'(NUM_WORDS))); // R5
endmodule

bind boot_select boot_select_chk #(
  .DELAY_CYCLES (DELAY_CYCLES),
  .NUM_WORDS    (NUM_WORDS),
  .ADDR_W       (ADDR_W),
  .BASE_ADDR    (BASE_ADDR)
) u_chk (.*);

// File: tb/boot_select_bench.sv
module boot_select_bench;
  localparam int D    = 12;
  localparam int NW   = 8;
  localparam int BASE = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pin = 1'b1;
  logic        wdt = 1'b0;
  logic        rd_en;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        sel_isp, sel_user, sel_autobaud, done;

  logic [31:0] mem [NW];
  logic [7:0]  addr_log [16];
  int          log_n;
  int          checks = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  boot_select #(
    .DELAY_CYCLES (D),
    .DATA_W       (32),
    .ADDR_W       (8),
    .NUM_WORDS    (NW),
    .BASE_ADDR    (BASE)
  ) u_boot_select (
    .clk, .rst_n, .boot_req_pin(pin), .wdt_overflow(wdt),
    .rd_en, .rd_addr, .rd_data, .sel_isp, .sel_user, .sel_autobaud, .done
  );

  // Code memory model with one cycle of read latency, plus an address log.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) log_n <= 0;
    else if (rd_en) begin
      rd_data <= mem[3'(rd_addr - 8'(BASE))];
      if (log_n < 16) addr_log[log_n] <= rd_addr;
      log_n <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] bench_sum();
    logic [31:0] s = 32'd0;
    for (int i = NW - 1; i >= 0; i--) s = s + mem[i];
    return s;
  endfunction

  function automatic logic [2:0] bench_exit(input bit p, input bit w);
    if (!p && !w)            return 3'b100;
    if (bench_sum() == 32'd0) return 3'b010;
    return 3'b001;
  endfunction

  task automatic fill_random(input bit valid);
    logic [31:0] partial = 32'd0;
    for (int i = 0; i < NW; i++) mem[i] = $urandom;
    for (int i = 0; i < NW - 1; i++) partial = partial + mem[i];
    if (valid) mem[NW-1] = ~partial + 32'd1;
    else if (bench_sum() == 32'd0) mem[0] = mem[0] ^ 32'd1;
  endtask

  task automatic run_case(input bit p, input bit w, input int flip_at);
    int n = 0;
    logic [2:0] exp_sel, got;
    int exp_n;
    bit req = !p && !w;
    @(negedge clk);
    rst_n = 1'b0; pin = p; wdt = w;
    repeat (3) @(negedge clk);
    chk({sel_isp, sel_user, sel_autobaud, done, rd_en} == 5'b0, "R1", "reset outputs",
        {27'd0, sel_isp, sel_user, sel_autobaud, done, rd_en}, 32'd0);
    exp_sel = bench_exit(p, w);
    exp_n   = req ? D + 2 : D + 2 + 2 * NW;
    rst_n = 1'b1;
    while (n < 400) begin
      @(posedge clk); #1;
      n++;
      if (n == flip_at) pin = ~p;
      if (n == 1)
        chk({sel_isp, sel_user, sel_autobaud, done, rd_en} == 5'b0, "R1", "first cycle idle",
            {27'd0, sel_isp, sel_user, sel_autobaud, done, rd_en}, 32'd0);
      if (done) break;
    end
    chk(n == exp_n, "R2", "done cycle", 32'(n), 32'(exp_n));
    got = {sel_isp, sel_user, sel_autobaud};
    chk(got == exp_sel, req ? "R3" : (exp_sel == 3'b010 ? "R6" : "R7"),
        (w && !p) ? "exit with wdt override R4" : "exit select", 32'(got), 32'(exp_sel));
    chk(log_n == (req ? 0 : NW), req ? "R3" : "R5", "read count", 32'(log_n), req ? 0 : NW);
    if (!req)
      for (int i = 0; i < NW; i++)
        chk(addr_log[i] == 8'(BASE + i), "R5", "read address order",
            32'(addr_log[i]), 32'(BASE + i));
    @(posedge clk); #1;
    chk(done == 1'b0, "R8", "done pulse width", 32'(done), 32'd0);
    pin = ~pin; wdt = ~wdt;
    repeat (6) @(posedge clk);
    #1;
    chk({sel_isp, sel_user, sel_autobaud} == exp_sel && !done, "R10", "exit held after input change",
        {28'd0, sel_isp, sel_user, sel_autobaud, done}, {28'd0, exp_sel, 1'b0});
  endtask

  initial begin
    void'($urandom(32'd1234));
    // Directed corners
    for (int i = 0; i < NW; i++) mem[i] = 32'd0;
    run_case(1'b0, 1'b0, -1);              // R3 strap request
    run_case(1'b1, 1'b0, -1);              // R6 all-zero image is valid
    run_case(1'b0, 1'b1, -1);              // R4 watchdog cancels request
    mem[0] = 32'h8000_0000; mem[1] = 32'h8000_0000;
    run_case(1'b1, 1'b0, -1);              // R6 wrap to 2^32
    for (int i = 0; i < NW; i++) mem[i] = 32'hFFFF_FFFF;
    run_case(1'b1, 1'b1, -1);              // R7 nonzero sum
    fill_random(1'b1);
    run_case(1'b1, 1'b0, D + 1);           // R10 pin drops just after sample
    // R9: reset in the middle of the reads, then a fresh valid run
    fill_random(1'b0);
    @(negedge clk); rst_n = 1'b0; pin = 1'b1; wdt = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (D + 7) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk({sel_isp, sel_user, sel_autobaud, rd_en} == 4'b0, "R9", "mid-read reset clears",
        {28'd0, sel_isp, sel_user, sel_autobaud, rd_en}, 32'd0);
    fill_random(1'b1);
    run_case(1'b1, 1'b0, -1);              // R9 partial sum discarded
    // Random mix
    for (int k = 0; k < 24; k++) begin
      fill_random(1'($urandom % 2));
      run_case(1'($urandom % 2), 1'($urandom % 2), -1);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule